// File: doc/BRIEF.md
# Reset Escalation Unit

This block gathers reset requests from a set of functional sources and a set of destructive sources. It records each one in a sticky status register and decides which reset the system receives. A rising edge on an enabled functional source normally produces a one-cycle functional reset. Once a programmable number of functional resets has been counted, the next functional request is promoted to a destructive reset. Destructive resets are counted as well. Once a second programmable number of them has occurred, the next destructive request leaves the destructive reset output asserted until power is cycled.

Software reaches the block over a plain 32-bit register bus. A write takes effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr` and have no side effects. The block has no streaming data path, so every pin is a plain level or strobe and there is no back-pressure. Functional sources can be masked individually. A masked source still records its status bit, and while that bit is set it raises the interrupt instead of a reset. The active-low `por_n` input is the power-on reset and clears everything asynchronously.

Top module: `rst_escalator`

## Requirements
- R1: After power-on the registers read as follows: destructive status (0x00) = 0x1, with bit 0 the power-on flag; functional status (0x08) = 0; source mask (0x0C) = 0; functional counter (0x14) = 0; functional threshold (0x18) = 15; destructive threshold (0x1C) = 0. `func_rst`, `dest_rst` and `irq` are low.
- R2: The status bits are set while their source is high and stay set after the source falls. Functional status bit i belongs to `func_evt[i]`. Destructive status bit 1+j belongs to `dest_evt[j]`. Destructive status bit ND+1 (bit 4 by default) flags a promoted functional request.
- R3: Writing 1 to a status bit clears it only if its source is low in that cycle. If the source is still high, the bit stays set.
- R4: A rising edge on an unmasked functional source gives a one-cycle `func_rst` pulse in the following cycle. It also raises the counter at 0x14 (bits 3:0) by one, saturating at 15.
- R5: Setting bit i of the mask register (0x0C) stops source i from causing a reset or being counted. `irq` is high while any status bit is set together with its mask bit.
- R6: With a nonzero functional threshold, a functional request that arrives while the counter is at or above the threshold becomes a destructive reset and sets the promotion flag.
- R7: A functional threshold of 0 disables promotion.
- R8: Every destructive reset, whether from a source or promoted, pulses `dest_rst` for one cycle. It also restores the functional threshold to 15 and clears the counter. The destructive threshold keeps its value.
- R9: With a nonzero destructive threshold, a destructive request that arrives after that many destructive resets holds `dest_rst` high until `por_n` falls, and all further requests are ignored. A destructive threshold of 0 disables this hold.
- R10: When functional and destructive requests arrive in the same cycle, only the destructive reset happens, and the functional request is not counted.
- R11: The counter register is read-only. The threshold registers store only bits 3:0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| func_evt | input | NF | Functional reset requests, level |
| dest_evt | input | ND | Destructive reset requests, level |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` |
| func_rst | output | 1 | Functional reset pulse |
| dest_rst | output | 1 | Destructive reset pulse, or held high when locked |
| irq | output | 1 | Masked functional source pending |

## Verification
The bench builds the block with its defaults: four functional sources, three destructive sources, and 4-bit counters and thresholds. With these values the promotion flag lands at status bit 4, and the counter saturates within 17 functional pulses, so the test reaches saturation and both threshold-disable cases in a short run. With a destructive threshold of 2, the lock-up is reached after three destructive requests. A power-on reset in the middle of the run shows which state survives and which is cleared.

// File: rtl/rstesc_pkg.sv
package rstesc_pkg;
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  localparam logic [7:0] OFS_DSTAT = 8'h00;
  localparam logic [7:0] OFS_FSTAT = 8'h08;
  localparam logic [7:0] OFS_MASK  = 8'h0C;
  localparam logic [7:0] OFS_FCNT  = 8'h14;
  localparam logic [7:0] OFS_FTHR  = 8'h18;
  localparam logic [7:0] OFS_DTHR  = 8'h1C;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction
endpackage

// File: rtl/rstesc_rise.sv
module rstesc_rise #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) lvl_q[i] <= 1'b0;
      else        lvl_q[i] <= lvl_i[i];
    end
    assign rise_o[i] = lvl_i[i] & ~lvl_q[i];
  end
endmodule

// File: rtl/rstesc_sticky.sv
module rstesc_sticky #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] clr_ok;
  assign clr_ok = clr_i & ~src_i;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) stat_o <= RST_VAL;
    else        stat_o <= (stat_o & ~clr_ok) | set_i;
  end
endmodule

// File: rtl/rstesc_engine.sv
module rstesc_engine
  import rstesc_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             fire_f,
  input  logic             fire_d,
  input  logic [CNT_W-1:0] fthr_i,
  input  logic [CNT_W-1:0] dthr_i,
  output logic             func_pulse_o,
  output logic             dest_pulse_o,
  output logic             lock_o,
  output logic             dest_now_o,
  output logic             promote_o,
  output logic [CNT_W-1:0] fcnt_o
);
  logic [CNT_W-1:0] fcnt_q, dcnt_q;
  logic             func_q, dest_q, lock_q;
  logic             f_over, d_over, do_func, do_dest, promote;

  always_comb begin
    f_over  = (fthr_i != '0) && (fcnt_q >= fthr_i);
    d_over  = (dthr_i != '0) && (dcnt_q >= dthr_i);
    promote = !lock_q && fire_f && !fire_d && f_over;
    do_dest = !lock_q && (fire_d || promote);
    do_func = !lock_q && fire_f && !fire_d && !f_over;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      fcnt_q <= '0;
      dcnt_q <= '0;
      func_q <= 1'b0;
      dest_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      func_q <= do_func;
      dest_q <= do_dest;
      if (do_dest) begin
        fcnt_q <= '0;
        dcnt_q <= sat_inc(dcnt_q);
        if (d_over) lock_q <= 1'b1;
      end else if (do_func) begin
        fcnt_q <= sat_inc(fcnt_q);
      end
    end
  end

  assign func_pulse_o = func_q;
  assign dest_pulse_o = dest_q;
  assign lock_o       = lock_q;
  assign dest_now_o   = do_dest;
  assign promote_o    = promote;
  assign fcnt_o       = fcnt_q;
endmodule

// File: rtl/rst_escalator.sv
module rst_escalator
  import rstesc_pkg::*;
#(
  parameter int NF = 4,
  parameter int ND = 3,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic [NF-1:0] func_evt,
  input  logic [ND-1:0] dest_evt,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          func_rst,
  output logic          dest_rst,
  output logic          irq
);
  localparam int DSW = ND + 2;

  logic [NF-1:0]    f_rise, fstat, fmask_q;
  logic [ND-1:0]    d_rise;
  logic [DSW-1:0]   dstat;
  logic [CNT_W-1:0] fthr_q, dthr_q, fcnt_w;
  logic             fire_f, fire_d, func_w, dest_pulse_w, lock_w, dest_now_w, promote_w;
  logic             wr_dstat, wr_fstat, wr_mask, wr_fthr, wr_dthr;
  logic [DW-1:0]    unused_wdata;

  assign unused_wdata = bus_wdata;

  assign wr_dstat = bus_wr && (bus_addr == AW'(OFS_DSTAT));
  assign wr_fstat = bus_wr && (bus_addr == AW'(OFS_FSTAT));
  assign wr_mask  = bus_wr && (bus_addr == AW'(OFS_MASK));
  assign wr_fthr  = bus_wr && (bus_addr == AW'(OFS_FTHR));
  assign wr_dthr  = bus_wr && (bus_addr == AW'(OFS_DTHR));

  rstesc_rise #(.W(NF)) u_frise (.clk(clk), .por_n(por_n), .lvl_i(func_evt), .rise_o(f_rise));
  rstesc_rise #(.W(ND)) u_drise (.clk(clk), .por_n(por_n), .lvl_i(dest_evt), .rise_o(d_rise));

  assign fire_f = |(f_rise & ~fmask_q);
  assign fire_d = |d_rise;

  rstesc_sticky #(.W(NF), .RST_VAL('0)) u_fstat (
    .clk(clk), .por_n(por_n),
    .set_i(func_evt), .src_i(func_evt),
    .clr_i(wr_fstat ? bus_wdata[NF-1:0] : '0),
    .stat_o(fstat)
  );

  rstesc_sticky #(.W(DSW), .RST_VAL(DSW'(1))) u_dstat (
    .clk(clk), .por_n(por_n),
    .set_i({promote_w, dest_evt, 1'b0}),
    .src_i({1'b0, dest_evt, 1'b0}),
    .clr_i(wr_dstat ? bus_wdata[DSW-1:0] : '0),
    .stat_o(dstat)
  );

  rstesc_engine u_eng (
    .clk(clk), .por_n(por_n),
    .fire_f(fire_f), .fire_d(fire_d),
    .fthr_i(fthr_q), .dthr_i(dthr_q),
    .func_pulse_o(func_w), .dest_pulse_o(dest_pulse_w), .lock_o(lock_w),
    .dest_now_o(dest_now_w), .promote_o(promote_w), .fcnt_o(fcnt_w)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      fthr_q  <= CNT_MAX;
      dthr_q  <= '0;
      fmask_q <= '0;
    end else begin
      if (dest_now_w)   fthr_q  <= CNT_MAX;
      else if (wr_fthr) fthr_q  <= bus_wdata[CNT_W-1:0];
      if (wr_dthr)      dthr_q  <= bus_wdata[CNT_W-1:0];
      if (wr_mask)      fmask_q <= bus_wdata[NF-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(OFS_DSTAT): bus_rdata = DW'(dstat);
      AW'(OFS_FSTAT): bus_rdata = DW'(fstat);
      AW'(OFS_MASK):  bus_rdata = DW'(fmask_q);
      AW'(OFS_FCNT):  bus_rdata = DW'(fcnt_w);
      AW'(OFS_FTHR):  bus_rdata = DW'(fthr_q);
      AW'(OFS_DTHR):  bus_rdata = DW'(dthr_q);
      default:        bus_rdata = '0;
    endcase
  end

  assign func_rst = func_w;
  assign dest_rst = dest_pulse_w | lock_w;
  assign irq      = |(fstat & fmask_q);
endmodule

// File: rtl/rstesc_chk.sv
module rstesc_chk (
  input logic       clk,
  input logic       por_n,
  input logic       func_rst,
  input logic       dest_rst,
  input logic       lock,
  input logic       dest_pulse,
  input logic [3:0] fthr,
  input logic [3:0] fcnt
);
  // R10
  rst_excl_chk: assert property (@(posedge clk) disable iff (!por_n)
    !(func_rst && dest_rst));

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    lock |=> (lock && dest_rst));

  // R9
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    lock |-> !func_rst);

  // R8
  thr_restore_chk: assert property (@(posedge clk) disable iff (!por_n)
    dest_pulse |-> (fthr == 4'hF && fcnt == 4'h0));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!por_n)
    func_rst |-> (fcnt == (($past(fcnt) == 4'hF) ? 4'hF : $past(fcnt) + 4'h1)));
endmodule

bind rst_escalator rstesc_chk u_chk (
  .clk(clk), .por_n(por_n), .func_rst(func_rst), .dest_rst(dest_rst),
  .lock(lock_w), .dest_pulse(dest_pulse_w), .fthr(fthr_q), .fcnt(fcnt_w)
);

// File: tb/rst_escalator_tb.sv
module rst_escalator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 4;
  localparam int ND = 3;
  localparam int WDOG = 20000;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic [NF-1:0] func_evt = '0;
  logic [ND-1:0] dest_evt = '0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          func_rst, dest_rst, irq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  int m_dstat, m_fstat, m_fmask, m_fcnt, m_fthr, m_dthr, m_dcnt, pf, pd;
  bit m_func, m_dest, m_lock;

  rst_escalator u_dut (
    .clk(clk), .por_n(por_n), .func_evt(func_evt), .dest_evt(dest_evt),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .func_rst(func_rst), .dest_rst(dest_rst), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic model_reset();
    m_dstat = 1; m_fstat = 0; m_fmask = 0; m_fcnt = 0; m_fthr = 15;
    m_dthr = 0; m_dcnt = 0; pf = 0; pd = 0;
    m_func = 0; m_dest = 0; m_lock = 0;
  endtask

  task automatic model_step();
    int fe, de, frise, drise, wd, w0, w8;
    bit ff, fd, over, dover, promo, dd, df;
    fe = int'(func_evt); de = int'(dest_evt); wd = int'(bus_wdata);
    frise = fe & ~pf; drise = de & ~pd; pf = fe; pd = de;
    ff = (frise & ~m_fmask) != 0;
    fd = drise != 0;
    over  = (m_fthr != 0) && (m_fcnt >= m_fthr);
    dover = (m_dthr != 0) && (m_dcnt >= m_dthr);
    promo = !m_lock && ff && !fd && over;
    dd = !m_lock && (fd || promo);
    df = !m_lock && ff && !fd && !over;
    w0 = (bus_wr && bus_addr == 8'h00) ? wd : 0;
    w8 = (bus_wr && bus_addr == 8'h08) ? wd : 0;
    m_fstat = ((m_fstat & ~(w8 & ~fe)) | fe) & ((1 << NF) - 1);
    m_dstat = ((m_dstat & ~(w0 & ~(de << 1))) | (de << 1) | (int'(promo) << (ND + 1)))
              & ((1 << (ND + 2)) - 1);
    if (bus_wr && bus_addr == 8'h0C) m_fmask = wd & ((1 << NF) - 1);
    if (bus_wr && bus_addr == 8'h18) m_fthr = wd & 15;
    if (bus_wr && bus_addr == 8'h1C) m_dthr = wd & 15;
    m_func = df;
    m_dest = dd;
    if (dd) begin
      m_fthr = 15; m_fcnt = 0;
      if (dover) m_lock = 1;
      if (m_dcnt < 15) m_dcnt++;
    end else if (df) begin
      if (m_fcnt < 15) m_fcnt++;
    end
  endtask

  function automatic int model_reg(input logic [7:0] a);
    case (a)
      8'h00: return m_dstat;
      8'h08: return m_fstat;
      8'h0C: return m_fmask;
      8'h14: return m_fcnt;
      8'h18: return m_fthr;
      8'h1C: return m_dthr;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) model_reset();
    else        model_step();
  end

  // every-cycle comparison of the outputs against the model
  always @(negedge clk) begin
    if (por_n) begin
      check("R4", "func_rst", func_rst, m_func);
      check("R8", "dest_rst", dest_rst, m_dest | m_lock);
      check("R5", "irq", irq, (m_fstat & m_fmask) != 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      report();
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); bus_addr = a; #1;
    check(req, $sformatf("reg %0h", a), bus_rdata, exp);
    check(req, $sformatf("model reg %0h", a), bus_rdata, model_reg(a));
  endtask

  task automatic fpulse(input logic [NF-1:0] m);
    @(negedge clk); func_evt = m;
    @(negedge clk); func_evt = '0;
  endtask

  task automatic dpulse(input logic [ND-1:0] m);
    @(negedge clk); dest_evt = m;
    @(negedge clk); dest_evt = '0;
  endtask

  task automatic power_on();
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    // R1 reset state
    check("R1", "func_rst", func_rst, 0);
    check("R1", "dest_rst", dest_rst, 0);
    check("R1", "irq", irq, 0);
    rd(8'h00, 1, "R1"); rd(8'h08, 0, "R1"); rd(8'h0C, 0, "R1");
    rd(8'h14, 0, "R1"); rd(8'h18, 15, "R1"); rd(8'h1C, 0, "R1");
    // R3 power-on flag clears by write-1
    wr(8'h00, 1); rd(8'h00, 0, "R3");
    // R4 counting functional resets
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); func_evt = 4'h1;
      @(negedge clk); func_evt = '0;
      check("R4", "func_rst pulse", func_rst, 1);
    end
    rd(8'h14, 3, "R4"); rd(8'h08, 1, "R2");
    // R3 clear blocked while source high
    @(negedge clk); func_evt = 4'h2;
    wr(8'h08, 2); rd(8'h08, 3, "R3");
    @(negedge clk); func_evt = '0;
    wr(8'h08, 3); rd(8'h08, 0, "R3");
    rd(8'h14, 4, "R4");
    // R5 masked source
    wr(8'h0C, 4); fpulse(4'h4);
    rd(8'h08, 4, "R2"); check("R5", "irq set", irq, 1);
    rd(8'h14, 4, "R5");
    wr(8'h08, 4); @(negedge clk); check("R5", "irq cleared", irq, 0);
    // R6 promotion
    wr(8'h18, 2);
    @(negedge clk); func_evt = 4'h1;
    @(negedge clk); func_evt = '0;
    check("R6", "promoted dest_rst", dest_rst, 1);
    check("R6", "no func_rst", func_rst, 0);
    rd(8'h18, 15, "R8"); rd(8'h14, 0, "R6"); rd(8'h00, 32'h10, "R6");
    wr(8'h00, 32'h10); rd(8'h00, 0, "R3");
    // R7 threshold zero, saturation
    wr(8'h18, 0);
    for (int i = 0; i < 17; i++) fpulse(4'h1);
    rd(8'h14, 15, "R7"); rd(8'h00, 0, "R7");
    // R10 simultaneous
    @(negedge clk); func_evt = 4'h1; dest_evt = 3'h1;
    @(negedge clk); func_evt = '0; dest_evt = '0;
    check("R10", "dest_rst", dest_rst, 1);
    check("R10", "func_rst", func_rst, 0);
    rd(8'h14, 0, "R10"); rd(8'h00, 2, "R2");
    // R11 register access rules
    wr(8'h14, 7); rd(8'h14, 0, "R11");
    wr(8'h1C, 32'hF3); rd(8'h1C, 3, "R11");
    rd(8'h30, 0, "R11");
    // R1 again after power-on in mid run
    power_on();
    rd(8'h00, 1, "R1"); rd(8'h0C, 0, "R1"); rd(8'h18, 15, "R1"); rd(8'h1C, 0, "R1");
    // R9 destructive lock-up
    wr(8'h1C, 2); wr(8'h18, 5);
    dpulse(3'h1);
    rd(8'h18, 15, "R8"); rd(8'h1C, 2, "R8");
    dpulse(3'h2);
    @(negedge clk); check("R9", "released before limit", dest_rst, 0);
    dpulse(3'h4);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); check("R9", "held", dest_rst, 1);
    end
    fpulse(4'h1);
    check("R9", "func ignored", func_rst, 0);
    power_on();
    @(negedge clk); check("R9", "released by power-on", dest_rst, 0);
    rd(8'h1C, 0, "R9");
    // R9 disabled hold
    for (int i = 0; i < 5; i++) dpulse(3'h1);
    @(negedge clk); check("R9", "no hold when zero", dest_rst, 0);
    repeat (3) @(negedge clk);
    report();
  end
endmodule